// File: doc/BRIEF.md
# Programmable Millisecond Interrupt Timer

This block is a host-programmed interval timer that raises an interrupt after a chosen number of milliseconds, from 1 to 63. A base strobe `tick_i` arrives at a fixed fraction of a millisecond. An internal prescaler divides it by `PRESC_DIV` to form one millisecond step. The host writes one byte to the timer register. Bit 7 picks the mode: 0 is a single countdown and 1 is periodic. Bits 5..0 give the period in milliseconds, and a value of 0 switches the timer off.

When the count reaches zero, a sticky status flag is set and drives `irq_o`. The host reads this flag at the status address. It clears the flag by writing a 1 to bit 0 at that address. Any write to the timer register restarts the timer from the new value, and the prescaler restarts too, so the first millisecond is always complete. Reading the timer register returns the live count, not the programmed period.

Top module: `ms_irq_timer`

## Requirements
- R1: After reset, the timer register reads 0x00, the status register reads 0x00 and `irq_o` is low.
- R2: Reading the timer register (address 0) returns the mode in bit 7, 0 in bit 6 whatever was written there, and the live count in bits 5..0. Reading the status register (address 1) returns the flag in bit 0 and zeros in all other bits.
- R3: A write of a nonzero period N sets the flag exactly N*PRESC_DIV base ticks after the write. The tick in the cycle of the write is not counted.
- R4: In mode 0, the flag is set once. The timer then stops with a count of 0, and further ticks raise no second interrupt.
- R5: In mode 1, the count reloads to N when it expires, and the flag is set again every N*PRESC_DIV ticks.
- R6: Writing a period of 0 stops the timer at once. The count reads 0 and no interrupt follows, however many ticks arrive.
- R7: A timer write with a nonzero period before expiry loads the new value and restarts timing from the beginning, including the partial millisecond already counted.
- R8: The flag stays set until a status write with bit 0 = 1. Reads do not clear it, and a status write with bit 0 = 0 leaves it unchanged.
- R9: When an expiry and a status clear fall in the same cycle, the flag ends up set.
- R10: Ticks have no effect while the timer is stopped.
- R11: While the timer runs, the count drops by one every PRESC_DIV ticks and is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base time strobe, one cycle wide; PRESC_DIV strobes make one millisecond |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 timer, 1 status |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Sticky timer interrupt flag |

## Verification
The hardest cases to reach from the ports are the coincidences. One is an expiry tick landing in the same cycle as a status clear. Another is a tick landing in the same cycle as a timer write. A third is a rewrite that falls partway through a millisecond. The stimulus counts base ticks exactly from each write, so it can place a write or clear on the expiring tick or just before it. The reference model tracks the remaining base ticks as a single integer, and the visible count is derived from that integer on every clock.

// File: rtl/mst_pkg.sv
package mst_pkg;
  localparam int unsigned CNT_W    = 6;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned MODE_POS = 7;

  typedef enum logic {
    ADDR_TIMER  = 1'b0,
    ADDR_STATUS = 1'b1
  } reg_addr_e;

  typedef struct packed {
    logic             periodic;
    logic [CNT_W-1:0] period;
  } tmr_cfg_t;
endpackage

// File: rtl/mst_rst_sync.sv
module mst_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_no = sync_q;
endmodule

// File: rtl/mst_host_if.sv
module mst_host_if
  import mst_pkg::*;
(
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              mode_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              flag_i,
  output logic              load_o,
  output tmr_cfg_t          load_cfg_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] reg_rdata_o
);
  logic sel_timer;
  logic wdata_unused;

  assign sel_timer = (reg_addr_i == ADDR_TIMER);
  assign load_o    = reg_wr_i & sel_timer;
  assign clr_o     = reg_wr_i & ~sel_timer & reg_wdata_i[0];

  assign load_cfg_o.periodic = reg_wdata_i[MODE_POS];
  assign load_cfg_o.period   = reg_wdata_i[CNT_W-1:0];

  assign wdata_unused = ^reg_wdata_i[MODE_POS-1:CNT_W];

  always_comb begin
    reg_rdata_o = '0;
    if (sel_timer) begin
      reg_rdata_o[MODE_POS]  = mode_i;
      reg_rdata_o[CNT_W-1:0] = cnt_i;
    end else begin
      reg_rdata_o[0] = flag_i;
    end
  end
endmodule

// File: rtl/mst_prescaler.sv
module mst_prescaler #(
  parameter int unsigned PRESC_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic restart_i,
  output logic ms_step_o
);
  localparam int unsigned PRE_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

  generate
    if (PRESC_DIV <= 1) begin : g_direct
      assign ms_step_o = tick_i & run_i & ~restart_i;
    end else begin : g_divide
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESC_DIV - 1);
      logic [PRE_W-1:0] pre_q, pre_d;
      logic             pre_en;
      logic             at_last;

      assign at_last   = (pre_q == PRE_LAST);
      assign ms_step_o = tick_i & run_i & ~restart_i & at_last;

      always_comb begin
        pre_en = 1'b0;
        pre_d  = pre_q;
        if (restart_i || !run_i) begin
          pre_en = (pre_q != '0);
          pre_d  = '0;
        end else if (tick_i) begin
          pre_en = 1'b1;
          pre_d  = at_last ? '0 : pre_q + PRE_W'(1);
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pre_q <= '0;
        end else if (pre_en) begin
          pre_q <= pre_d;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mst_counter.sv
module mst_counter
  import mst_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  tmr_cfg_t         load_cfg_i,
  input  logic             ms_step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             mode_o,
  output logic             run_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  tmr_cfg_t         cfg_q, cfg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             upd_en;
  logic             expire;

  assign upd_en = load_i | (run_q & ms_step_i);

  always_comb begin
    cfg_d  = cfg_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    expire = 1'b0;
    if (load_i) begin
      cfg_d = load_cfg_i;
      cnt_d = load_cfg_i.period;
      run_d = |load_cfg_i.period;
    end else if (run_q && ms_step_i) begin
      if (cnt_q == CNT_ONE) begin
        expire = 1'b1;
        if (cfg_q.periodic) begin
          cnt_d = cfg_q.period;
        end else begin
          cnt_d = '0;
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (upd_en) begin
      cfg_q <= cfg_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign mode_o   = cfg_q.periodic;
  assign run_o    = run_q;
  assign expire_o = expire;
endmodule

// File: rtl/mst_irq_flag.sv
module mst_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ms_irq_timer.sv
module ms_irq_timer
  import mst_pkg::*;
#(
  parameter int unsigned PRESC_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic             rst_sync_n;
  logic             tmr_load;
  tmr_cfg_t         tmr_cfg;
  logic             flag_clr;
  logic             ms_step;
  logic [CNT_W-1:0] tmr_cnt;
  logic             tmr_mode;
  logic             tmr_run;
  logic             tmr_expire;
  logic             flag;

  mst_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  mst_host_if u_host_if (
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .mode_i      (tmr_mode),
    .cnt_i       (tmr_cnt),
    .flag_i      (flag),
    .load_o      (tmr_load),
    .load_cfg_o  (tmr_cfg),
    .clr_o       (flag_clr),
    .reg_rdata_o (reg_rdata_o)
  );

  mst_prescaler #(.PRESC_DIV(PRESC_DIV)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .tick_i    (tick_i),
    .run_i     (tmr_run),
    .restart_i (tmr_load),
    .ms_step_o (ms_step)
  );

  mst_counter u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .load_i     (tmr_load),
    .load_cfg_i (tmr_cfg),
    .ms_step_i  (ms_step),
    .cnt_o      (tmr_cnt),
    .mode_o     (tmr_mode),
    .run_o      (tmr_run),
    .expire_o   (tmr_expire)
  );

  mst_irq_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .set_i  (tmr_expire),
    .clr_i  (flag_clr),
    .flag_o (flag)
  );

  assign irq_o = flag;
endmodule

// File: rtl/mst_timer_checker.sv
module mst_timer_checker
  import mst_pkg::*;
(
  input logic              clk_i,
  input logic              rst_n,
  input logic              tick_i,
  input logic              reg_wr_i,
  input logic              reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              irq_o,
  input logic              run,
  input logic [CNT_W-1:0]  cnt,
  input logic              mode
);
  logic wr_timer, wr_clear;
  assign wr_timer = reg_wr_i & (reg_addr_i == ADDR_TIMER);
  assign wr_clear = reg_wr_i & (reg_addr_i == ADDR_STATUS) & reg_wdata_i[0];

  assert_irq_source_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(tick_i) && $past(run)));

  assert_oneshot_halt_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($rose(irq_o) && !mode) |-> (!run && cnt == '0));

  assert_periodic_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($rose(irq_o) && mode) |-> (run && cnt != '0));

  assert_stop_on_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_timer && reg_wdata_i[CNT_W-1:0] == '0) |=> (!run && cnt == '0));

  assert_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_timer && reg_wdata_i[CNT_W-1:0] != '0) |=> (run && cnt == $past(reg_wdata_i[CNT_W-1:0])));

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irq_o && !wr_clear) |=> irq_o);

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!run && !wr_timer) |=> (!run && cnt == '0));

  assert_live_nonzero_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    run |-> (cnt != '0));
endmodule

bind ms_irq_timer mst_timer_checker u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_sync_n),
  .tick_i      (tick_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .run         (tmr_run),
  .cnt         (tmr_cnt),
  .mode        (tmr_mode)
);

// File: tb/ms_irq_timer_tb_top.sv
module ms_irq_timer_tb_top;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       wr;
  logic       addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int    total = 0;
  int    bad   = 0;
  bit    cmp_on = 1'b0;
  string phase = "R1";

  int m_mode, m_period, m_left, m_run, m_flag;

  always #2 clk = ~clk;

  ms_irq_timer #(.PRESC_DIV(DIV)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  // Behavioural reference: remaining base ticks until expiry.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_period = 0; m_left = 0; m_run = 0; m_flag = 0;
    end else begin
      bit exp_now;
      exp_now = 1'b0;
      if (wr && addr == 1'b0) begin
        m_mode   = wdata[7];
        m_period = wdata[5:0];
        m_left   = m_period * DIV;
        m_run    = (m_period != 0);
      end else if (m_run != 0 && tick) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          exp_now = 1'b1;
          if (m_mode != 0) m_left = m_period * DIV;
          else m_run = 0;
        end
      end
      if (exp_now) m_flag = 1;
      else if (wr && addr == 1'b1 && wdata[0]) m_flag = 0;
    end
  end

  function automatic logic [7:0] model_rd(logic a);
    logic [7:0] v;
    v = '0;
    if (a == 1'b0) begin
      v[7]   = m_mode[0];
      v[5:0] = (m_run != 0) ? 6'((m_left + DIV - 1) / DIV) : 6'd0;
    end else begin
      v[0] = m_flag[0];
    end
    return v;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(phase, rdata, model_rd(addr));
      chk(phase, {7'b0, irq}, {7'b0, m_flag[0]});
    end
  end

  task automatic step(input logic w, input logic a, input logic [7:0] d, input logic t);
    @(posedge clk);
    #1;
    wr = w; addr = a; wdata = d; tick = t;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b0, 1'b0, 8'h00, 1'b1);
      step(1'b0, 1'b0, 8'h00, 1'b0);
    end
  endtask

  task automatic chk_rd(input logic a, input logic [7:0] exp, input string req);
    step(1'b0, a, 8'h00, 1'b0);
    #0.5;
    chk(req, rdata, exp);
  endtask

  task automatic chk_irq(input logic exp, input string req);
    step(1'b0, 1'b0, 8'h00, 1'b0);
    #0.5;
    chk(req, {7'b0, irq}, {7'b0, exp});
  endtask

  task automatic clear_flag();
    step(1'b1, 1'b1, 8'h01, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; wr = 1'b0; addr = 1'b0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, 8'h00, 1'b0);
    cmp_on = 1'b1;

    phase = "R1";
    chk_rd(1'b0, 8'h00, "R1");
    chk_rd(1'b1, 8'h00, "R1");
    chk_irq(1'b0, "R1");

    phase = "R10";
    ticks(10);
    chk_rd(1'b0, 8'h00, "R10");
    chk_irq(1'b0, "R10");

    phase = "R2";
    step(1'b1, 1'b0, 8'h43, 1'b0);   // one-shot, 3 ms, bit 6 set
    chk_rd(1'b0, 8'h03, "R2");
    phase = "R11";
    ticks(4);
    chk_rd(1'b0, 8'h02, "R11");
    ticks(4);
    chk_rd(1'b0, 8'h01, "R11");
    phase = "R3";
    ticks(3);
    chk_irq(1'b0, "R3");
    ticks(1);
    chk_irq(1'b1, "R3");
    phase = "R4";
    chk_rd(1'b0, 8'h00, "R4");
    ticks(20);
    chk_rd(1'b0, 8'h00, "R4");
    phase = "R8";
    chk_rd(1'b1, 8'h01, "R2");
    chk_rd(1'b1, 8'h01, "R8");
    step(1'b1, 1'b1, 8'hFE, 1'b0);
    chk_irq(1'b1, "R8");
    clear_flag();
    chk_irq(1'b0, "R8");
    phase = "R4";
    ticks(20);
    chk_irq(1'b0, "R4");

    phase = "R5";
    step(1'b1, 1'b0, 8'h82, 1'b0);
    ticks(8);
    chk_irq(1'b1, "R5");
    chk_rd(1'b0, 8'h82, "R5");
    clear_flag();
    ticks(4);
    chk_rd(1'b0, 8'h81, "R5");
    chk_irq(1'b0, "R5");
    ticks(4);
    chk_irq(1'b1, "R5");
    clear_flag();

    phase = "R6";
    step(1'b1, 1'b0, 8'h85, 1'b0);
    ticks(6);
    step(1'b1, 1'b0, 8'h80, 1'b0);
    chk_rd(1'b0, 8'h80, "R6");
    ticks(40);
    chk_irq(1'b0, "R6");
    chk_rd(1'b0, 8'h80, "R6");

    phase = "R7";
    step(1'b1, 1'b0, 8'h05, 1'b0);
    ticks(18);
    chk_rd(1'b0, 8'h01, "R7");
    step(1'b1, 1'b0, 8'h04, 1'b0);
    chk_rd(1'b0, 8'h04, "R7");
    ticks(15);
    chk_irq(1'b0, "R7");
    ticks(1);
    chk_irq(1'b1, "R7");
    clear_flag();
    step(1'b1, 1'b0, 8'h01, 1'b0);
    ticks(3);
    step(1'b1, 1'b0, 8'h01, 1'b0);   // rewrite mid-millisecond
    ticks(3);
    chk_irq(1'b0, "R7");
    ticks(1);
    chk_irq(1'b1, "R7");
    clear_flag();

    phase = "R10";
    step(1'b1, 1'b0, 8'h01, 1'b1);   // tick in the write cycle is not counted
    ticks(3);
    chk_irq(1'b0, "R10");
    ticks(1);
    chk_irq(1'b1, "R10");
    clear_flag();

    phase = "R9";
    step(1'b1, 1'b0, 8'h81, 1'b0);
    ticks(3);
    step(1'b1, 1'b1, 8'h01, 1'b1);   // clear on the expiring tick
    chk_irq(1'b1, "R9");
    clear_flag();
    chk_irq(1'b0, "R8");
    step(1'b1, 1'b0, 8'h00, 1'b0);
    chk_rd(1'b0, 8'h00, "R6");

    cmp_on = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    total++;
    bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule